// File: doc/BRIEF.md
# Register-Programmed Serial Word Shifter

This block is the core of a serial flash controller. Software programs it through a small register port: a clock-control register (enable and divider), a device-control register holding per-chip-select clock polarity, clock phase and select polarity, up to four 32-bit data registers, a status register, and a command register. Writing a read or write command shifts one word of 1 to 128 bits on the serial clock, most significant bit first. The selected chip select stays asserted from that command until software issues an end-of-frame command, so a frame may span many words.

The shifting sequencer has three named states. `SH_IDLE` waits for an accepted word command (transition *launch*, into `SH_FIRST`). `SH_FIRST` is the first half of a bit period, with the clock at its idle level; when the divider tick arrives it takes the *leading-edge* transition into `SH_SECOND`. `SH_SECOND` is the second half, with the clock inverted; on the tick it takes *next-bit* back to `SH_FIRST`, or *finish* back to `SH_IDLE` after the last bit. Each half lasts divider+1 functional clock cycles.

In three-pin mode a single data line carries both directions: the block drives it for writes and releases it for reads. In normal mode writes leave on the output line and reads arrive on a separate input line.

Top module: `spi_word_engine`

## Requirements
- R1: After reset the status register reads 0, every chip-select pin is high, the serial clock is low, the data line enable is low and the command register reads 0.
- R2: Register addresses: 0 clock control (bit 31 enable, bits 15:0 divider), 1 device control, 2 command, 3 status (bit 0 busy, bit 1 word complete, bit 2 error), 4..7 data words 0..3. Command fields: chip select in bits 29:28, word length minus one in bits 25:19, operation in bits 18:16.
- R3: An accepted read (operation 1 or 5) or write (operation 2 or 6) sets busy and clears word complete on the next clock edge; busy lasts exactly 2 x length x (divider + 1) cycles, after which busy is 0 and word complete is 1.
- R4: For chip select n, device-control bit 8n is clock polarity: the idle clock level equals it, the first half of each bit holds that level and the second half its inverse, each half lasting divider + 1 cycles.
- R5: Writes send the low `length` bits of {data3, data2, data1, data0} most significant bit first; with clock phase (device-control bit 8n+2) 0 each bit is valid for its whole period, with phase 1 the line moves to the next bit at the leading edge.
- R6: Reads sample at the leading edge (phase 0) or trailing edge (phase 1) and place the word right-aligned in the data registers with all higher bits zero.
- R7: Device-control bit 8n+1 sets chip select n active high; the selected pin stays asserted across consecutive word commands and is released only by operation 4.
- R8: Operation bit 18 selects three-pin mode: reads then sample the shared line input and keep its output enable low; normal reads sample the separate input line.
- R9: A command write while busy leaves the command register and transfer unchanged and sets the sticky error bit, which clears only when 1 is written to status bit 2.
- R10: While clock-control bit 31 is 0, a word in progress freezes: the clock level and busy hold until the enable returns.
- R11: Operations 0, 3 and 7 start nothing: busy stays 0 and chip-select pins do not change.
- R12: The command register reads back the full written value, including the frame-count field in bits 11:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs | output | NCS | Chip-select pins, one per device |
| spi_d0_o | output | 1 | Shared/output data line value |
| spi_d0_oe | output | 1 | Output enable of the shared data line |
| spi_d0_i | input | 1 | Shared data line input (three-pin reads) |
| spi_d1_i | input | 1 | Separate serial input line (normal reads) |

## Verification
Busy and the cleared word-complete flag are due one edge after the command write, and the clock, chip-select and data-line levels are due in the cycle the reference model places them, counting elapsed cycles from that edge in units of divider + 1. The bench drives inputs and samples every output at the falling clock edge, so each comparison sees the state settled after the preceding rising edge. Read data is due one edge after the final bit and is checked through the data registers once busy has fallen, with the expected busy length counted at exactly 2 x length x (divider + 1) falling edges.

// File: rtl/wshift_pkg.sv
package wshift_pkg;
    typedef enum logic [1:0] {
        SH_IDLE,
        SH_FIRST,
        SH_SECOND
    } sh_state_t;

    localparam logic [2:0] A_CLKCTL = 3'd0;
    localparam logic [2:0] A_DEVCTL = 3'd1;
    localparam logic [2:0] A_CMD    = 3'd2;
    localparam logic [2:0] A_STATUS = 3'd3;

    localparam logic [2:0] OP_INVAL = 3'b100;
endpackage

// File: rtl/wshift_divider.sv
module wshift_divider #(
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            advance,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    assign tick = advance && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= (cnt == div) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wshift_engine.sv
module wshift_engine
    import wshift_pkg::*;
#(
    parameter int MAXW = 128,
    parameter int LENW = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_read,
    input  logic            three_pin,
    input  logic [LENW-1:0] len_m1,
    input  logic [MAXW-1:0] tx_word,
    input  logic            cpol_start,
    input  logic            cpha_start,
    input  logic            cpol_idle,
    input  logic            tick,
    input  logic            din_d0,
    input  logic            din_d1,
    output logic            busy,
    output logic            done,
    output logic [MAXW-1:0] rx_final,
    output logic            sclk,
    output logic            dout,
    output logic            dout_oe
);
    sh_state_t st, st_n;

    logic [MAXW-1:0] txw, rxsh;
    logic [LENW-1:0] bitcnt, lenr, idx;
    logic            rd_l, tp_l, cpol_l, cpha_l;
    logic            din, last, sample_now;

    assign din        = tp_l ? din_d0 : din_d1;
    assign last       = (bitcnt == lenr);
    assign sample_now = tick && (((st == SH_FIRST) && !cpha_l) ||
                                 ((st == SH_SECOND) && cpha_l));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SH_IDLE;
        else        st <= st_n;
    end

    // transitions: launch, leading-edge, next-bit, finish
    always_comb begin
        st_n = st;
        unique case (st)
            SH_IDLE:   if (start) st_n = SH_FIRST;
            SH_FIRST:  if (tick)  st_n = SH_SECOND;
            SH_SECOND: if (tick)  st_n = last ? SH_IDLE : SH_FIRST;
            default:   st_n = SH_IDLE;
        endcase
    end

    // word datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txw <= '0; rxsh <= '0; bitcnt <= '0; lenr <= '0;
            rd_l <= 1'b0; tp_l <= 1'b0; cpol_l <= 1'b0; cpha_l <= 1'b0;
        end else if (start && (st == SH_IDLE)) begin
            txw    <= tx_word;
            rxsh   <= '0;
            bitcnt <= '0;
            lenr   <= len_m1;
            rd_l   <= op_read;
            tp_l   <= three_pin;
            cpol_l <= cpol_start;
            cpha_l <= cpha_start;
        end else begin
            if (sample_now) rxsh <= {rxsh[MAXW-2:0], din};
            if (tick && (st == SH_SECOND) && !last) bitcnt <= bitcnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy     = (st != SH_IDLE);
        done     = (st == SH_SECOND) && tick && last;
        rx_final = ((st == SH_SECOND) && cpha_l) ? {rxsh[MAXW-2:0], din} : rxsh;
        idx      = (cpha_l && (st == SH_FIRST) && (bitcnt != '0)) ? bitcnt - 1'b1 : bitcnt;
        unique case (st)
            SH_IDLE: begin
                sclk = cpol_idle; dout = 1'b0; dout_oe = 1'b0;
            end
            SH_FIRST: begin
                sclk = cpol_l; dout = txw[lenr - idx]; dout_oe = !rd_l || !tp_l;
            end
            default: begin
                sclk = !cpol_l; dout = txw[lenr - idx]; dout_oe = !rd_l || !tp_l;
            end
        endcase
    end

    AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != SH_IDLE) && !tick) |=> $stable(sclk)); // R4
    AST_RX_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start && (st == SH_IDLE) && op_read && three_pin) && busy) |-> !dout_oe); // R8
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
    import wshift_pkg::*;
#(
    parameter int NCS  = 4,
    parameter int MAXW = 128,
    parameter int DIVW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [2:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           spi_sclk,
    output logic [NCS-1:0] spi_cs,
    output logic           spi_d0_o,
    output logic           spi_d0_oe,
    input  logic           spi_d0_i,
    input  logic           spi_d1_i
);
    localparam int CSW   = $clog2(NCS);
    localparam int LENW  = $clog2(MAXW);
    localparam int NDATA = MAXW / 32;
    localparam int DCW   = 8 * NCS;

    logic            clk_en;
    logic [DIVW-1:0] div_r;
    logic [DCW-1:0]  devctl;
    logic [31:0]     cmd_r;
    logic            err_r, wc_r, cs_on;
    logic [CSW-1:0]  cs_sel, cs_new;
    logic [31:0]     dreg [NDATA];
    logic [MAXW-1:0] tx_word, rx_final;
    logic [2:0]      op;
    logic            cmd_wr, accepted, is_rd, is_wr, start;
    logic            busy, done, tick;

    assign op       = reg_wdata[18:16];
    assign cs_new   = reg_wdata[28 +: CSW];
    assign cmd_wr   = reg_we && (reg_addr == A_CMD);
    assign accepted = cmd_wr && !busy;
    assign is_rd    = (op[1:0] == 2'b01);
    assign is_wr    = (op[1:0] == 2'b10);
    assign start    = accepted && (is_rd || is_wr);

    generate
        for (genvar i = 0; i < NDATA; i++) begin : g_tx
            assign tx_word[32*i +: 32] = dreg[i];
        end
        for (genvar n = 0; n < NCS; n++) begin : g_cs
            assign spi_cs[n] = (cs_on && (cs_sel == CSW'(n))) ? devctl[8*n+1] : !devctl[8*n+1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_en <= 1'b0; div_r <= '0; devctl <= '0; cmd_r <= '0;
            err_r <= 1'b0; wc_r <= 1'b0; cs_on <= 1'b0; cs_sel <= '0;
            for (int i = 0; i < NDATA; i++) dreg[i] <= '0;
        end else begin
            if (reg_we && (reg_addr == A_CLKCTL)) begin
                clk_en <= reg_wdata[31];
                div_r  <= reg_wdata[DIVW-1:0];
            end
            if (reg_we && (reg_addr == A_DEVCTL)) devctl <= reg_wdata[DCW-1:0];
            if (accepted) cmd_r <= reg_wdata;
            if (cmd_wr && busy) err_r <= 1'b1;
            else if (reg_we && (reg_addr == A_STATUS) && reg_wdata[2]) err_r <= 1'b0;
            if (start) begin
                wc_r   <= 1'b0;
                cs_on  <= 1'b1;
                cs_sel <= cs_new;
            end else if (accepted && (op == OP_INVAL)) begin
                cs_on <= 1'b0;
            end
            if (done) wc_r <= 1'b1;
            if (done && is_read_word) begin
                for (int i = 0; i < NDATA; i++) dreg[i] <= rx_final[32*i +: 32];
            end else if (reg_we && reg_addr[2]) begin
                dreg[reg_addr[1:0]] <= reg_wdata;
            end
        end
    end

    logic is_read_word;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     is_read_word <= 1'b0;
        else if (start) is_read_word <= is_rd;
    end

    always_comb begin
        unique case (reg_addr)
            A_CLKCTL: begin
                reg_rdata     = 32'(div_r);
                reg_rdata[31] = clk_en;
            end
            A_DEVCTL: reg_rdata = 32'(devctl);
            A_CMD:    reg_rdata = cmd_r;
            A_STATUS: reg_rdata = {29'b0, err_r, wc_r, busy};
            default:  reg_rdata = dreg[reg_addr[1:0]];
        endcase
    end

    wshift_divider #(.DIVW(DIVW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!busy),
        .advance (busy && clk_en),
        .div     (div_r),
        .tick    (tick)
    );

    wshift_engine #(.MAXW(MAXW), .LENW(LENW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_read    (is_rd),
        .three_pin  (op[2]),
        .len_m1     (reg_wdata[19 +: LENW]),
        .tx_word    (tx_word),
        .cpol_start (devctl[{cs_new, 3'b000}]),
        .cpha_start (devctl[{cs_new, 3'b010}]),
        .cpol_idle  (devctl[{cs_sel, 3'b000}]),
        .tick       (tick),
        .din_d0     (spi_d0_i),
        .din_d1     (spi_d1_i),
        .busy       (busy),
        .done       (done),
        .rx_final   (rx_final),
        .sclk       (spi_sclk),
        .dout       (spi_d0_o),
        .dout_oe    (spi_d0_oe)
    );

    AST_BUSY_NO_WC: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wc_r); // R3
    AST_DONE_WC: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (wc_r && !busy)); // R3
    AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> ($stable(cmd_r) && err_r)); // R9
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (spi_cs[cs_sel] == devctl[{cs_sel, 3'b001}])); // R7
endmodule

// File: tb/spi_word_engine_bench.sv
module spi_word_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_d0_o, spi_d0_oe;
    logic [3:0]  spi_cs;
    logic        spi_d0_i = 1'b0, spi_d1_i = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_word_engine u_spi_word_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs(spi_cs), .spi_d0_o(spi_d0_o), .spi_d0_oe(spi_d0_oe),
        .spi_d0_i(spi_d0_i), .spi_d1_i(spi_d1_i)
    );

    // behavioural reference model
    bit          m_act, m_en, m_rd, m_tp, m_cpol, m_cpha, m_cs_on;
    int          m_e, m_total, m_len, m_div, m_cs_sel;
    logic [31:0] m_dev;
    logic [31:0] m_d [4];
    logic [127:0] m_tx, m_rxpat = '0;

    function automatic logic [127:0] lowmask(int len);
        logic [127:0] one = 128'd1;
        return (one << len) - 128'd1;
    endfunction

    always @(posedge clk) begin
        bit was;
        logic [127:0] rv;
        logic [2:0] op;
        if (!rst_n) begin
            m_act = 0; m_en = 0; m_div = 0; m_dev = '0; m_cs_on = 0; m_cs_sel = 0;
            m_e = 0; m_total = 0; m_len = 1;
            for (int i = 0; i < 4; i++) m_d[i] = '0;
        end else begin
            was = m_act;
            if (m_act && m_en) begin
                m_e++;
                if (m_e == m_total) begin
                    m_act = 0;
                    if (m_rd) begin
                        rv = m_rxpat & lowmask(m_len);
                        for (int i = 0; i < 4; i++) m_d[i] = rv[32*i +: 32];
                    end
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    3'd0: begin m_en = reg_wdata[31]; m_div = int'(reg_wdata[15:0]); end
                    3'd1: m_dev = reg_wdata;
                    3'd2: if (!was) begin
                        op = reg_wdata[18:16];
                        if (op[1:0] == 2'b01 || op[1:0] == 2'b10) begin
                            m_act = 1; m_e = 0;
                            m_rd = (op[1:0] == 2'b01); m_tp = op[2];
                            m_len = int'(reg_wdata[25:19]) + 1;
                            m_total = 2 * m_len * (m_div + 1);
                            m_cs_sel = int'(reg_wdata[29:28]); m_cs_on = 1;
                            m_cpol = m_dev[8*m_cs_sel]; m_cpha = m_dev[8*m_cs_sel+2];
                            m_tx = {m_d[3], m_d[2], m_d[1], m_d[0]};
                        end else if (op == 3'b100) begin
                            m_cs_on = 0;
                        end
                    end
                    3'd4, 3'd5, 3'd6, 3'd7: m_d[reg_addr[1:0]] = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison and serial input drive, at the falling edge
    always @(negedge clk) begin
        int half, h, bk, idx;
        logic es, bitv;
        if (rst_n && !finished) begin
            half = m_act ? m_e / (m_div + 1) : 0;
            h = half % 2; bk = half / 2;
            es = m_act ? (m_cpol ^ h[0]) : m_dev[8*m_cs_sel];
            chk(spi_sclk === es, "R4", "sclk", 128'(spi_sclk), 128'(es));
            for (int n = 0; n < 4; n++) begin
                logic ec;
                ec = (m_cs_on && m_cs_sel == n) ? m_dev[8*n+1] : !m_dev[8*n+1];
                chk(spi_cs[n] === ec, "R7", "cs pin", 128'(spi_cs[n]), 128'(ec));
            end
            chk(spi_d0_oe === (m_act && (!m_rd || !m_tp)), "R8", "line enable",
                128'(spi_d0_oe), 128'(m_act && (!m_rd || !m_tp)));
            if (m_act && !m_rd) begin
                idx = (m_cpha && h == 0 && bk != 0) ? bk - 1 : bk;
                chk(spi_d0_o === m_tx[m_len-1-idx], "R5", "output bit",
                    128'(spi_d0_o), 128'(m_tx[m_len-1-idx]));
            end
            bitv = m_act ? m_rxpat[m_len-1-bk] : 1'b0;
            spi_d0_i = m_tp ? bitv : !bitv;
            spi_d1_i = m_tp ? !bitv : bitv;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk(int cs, int len, int op, int frame);
        return (32'(cs) << 28) | (32'(len - 1) << 19) | (32'(op) << 16) | 32'(frame);
    endfunction

    task automatic wait_idle(output int n);
        logic [31:0] s;
        n = 0;
        rd(3'd3, s);
        while (s[0] && n < 20000) begin
            @(negedge clk); n++;
            rd(3'd3, s);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, s0;
        logic [3:0]  pins;
        logic        sc;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd3, v); chk(v == 0, "R1", "status", 128'(v), 0);
        rd(3'd2, v); chk(v == 0, "R1", "command", 128'(v), 0);
        chk(spi_cs === 4'hF, "R1", "cs pins", 128'(spi_cs), 128'hF);
        chk(spi_sclk === 1'b0 && spi_d0_oe === 1'b0, "R1", "sclk/oe", 128'({spi_sclk, spi_d0_oe}), 0);

        wr(3'd0, 32'h8000_0001);
        wr(3'd1, 32'h0204_0700);

        // R2 / R3 / R12: 8-bit write on cs0, divider 1
        wr(3'd4, 32'h0000_00A5);
        wr(3'd2, mk(0, 8, 2, 12'h123));
        rd(3'd2, v); chk(v == mk(0, 8, 2, 12'h123), "R12", "command readback", 128'(v), 128'(mk(0, 8, 2, 12'h123)));
        rd(3'd3, v); chk(v == 32'h1, "R3", "busy after launch", 128'(v), 1);
        wait_idle(n); chk(n == 32, "R3", "busy length", 128'(n), 32);
        rd(3'd3, v); chk(v == 32'h2, "R3", "word complete", 128'(v), 2);
        chk(spi_cs[0] === 1'b0, "R7", "cs held after word", 128'(spi_cs[0]), 0);

        // second word of the same frame, then end of frame (R7)
        wr(3'd4, 32'h0000_003C);
        wr(3'd2, mk(0, 8, 2, 0));
        wait_idle(n);
        wr(3'd2, mk(0, 8, 4, 0));
        chk(spi_cs === 4'b0101, "R7", "frame released", 128'(spi_cs), 128'b0101);

        // R6 read on cs1: polarity 1, phase 1, divider 0
        wr(3'd0, 32'h8000_0000);
        m_rxpat = 128'hBEEF;
        wr(3'd2, mk(1, 16, 1, 0));
        wait_idle(n); chk(n == 32, "R3", "busy length div0", 128'(n), 32);
        rd(3'd4, v); chk(v == 32'h0000_BEEF, "R6", "16-bit read", 128'(v), 128'hBEEF);
        wr(3'd2, mk(1, 8, 4, 0));

        // R8 three-pin read on cs1
        m_rxpat = 128'h5A3C96;
        wr(3'd2, mk(1, 24, 5, 0));
        wait_idle(n);
        rd(3'd4, v); chk(v == 32'h005A_3C96, "R8", "three-pin read", 128'(v), 128'h5A3C96);
        wr(3'd2, mk(1, 8, 4, 0));

        // R5 128-bit write on cs2, phase 1, divider 2
        wr(3'd0, 32'h8000_0002);
        wr(3'd4, 32'h1122_3344); wr(3'd5, 32'h5566_7788);
        wr(3'd6, 32'h99AA_BBCC); wr(3'd7, 32'hF0E1_D2C3);
        wr(3'd2, mk(2, 128, 2, 0));
        wait_idle(n); chk(n == 768, "R5", "128-bit busy length", 128'(n), 768);

        // R6 128-bit read on cs2
        m_rxpat = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        wr(3'd2, mk(2, 128, 1, 0));
        wait_idle(n);
        rd(3'd7, v); chk(v == 32'h0123_4567, "R6", "read word 3", 128'(v), 128'h01234567);
        rd(3'd4, v); chk(v == 32'h7654_3210, "R6", "read word 0", 128'(v), 128'h76543210);
        wr(3'd2, mk(2, 8, 4, 0));

        // R9 command while busy
        wr(3'd0, 32'h8000_0003);
        wr(3'd2, mk(0, 8, 2, 12'h0AA));
        wr(3'd2, mk(3, 8, 1, 12'h077));
        rd(3'd3, v); chk(v[2] == 1'b1, "R9", "error flag", 128'(v), 128'h5);
        rd(3'd2, v); chk(v == mk(0, 8, 2, 12'h0AA), "R9", "command kept", 128'(v), 128'(mk(0, 8, 2, 12'h0AA)));
        wait_idle(n);
        chk(spi_cs === 4'b0100, "R9", "ignored select", 128'(spi_cs), 128'b0100);
        rd(3'd3, v); chk(v == 32'h6, "R9", "error sticky", 128'(v), 6);
        wr(3'd3, 32'h4);
        rd(3'd3, v); chk(v == 32'h2, "R9", "error cleared", 128'(v), 2);

        // R10 clock enable pause
        wr(3'd0, 32'h8000_0000);
        wr(3'd2, mk(0, 8, 2, 0));
        repeat (3) @(negedge clk);
        wr(3'd0, 32'h0000_0000);
        sc = spi_sclk;
        repeat (10) @(negedge clk);
        rd(3'd3, v);
        chk(spi_sclk === sc && v[0] == 1'b1, "R10", "paused", 128'({spi_sclk, v[0]}), 128'({sc, 1'b1}));
        wr(3'd0, 32'h8000_0000);
        wait_idle(n);
        rd(3'd3, v); chk(v == 32'h2, "R10", "resumed to completion", 128'(v), 2);

        // R11 unsupported operations
        pins = spi_cs;
        wr(3'd2, mk(1, 8, 7, 0));
        rd(3'd3, s0);
        chk(s0[0] == 1'b0 && spi_cs === pins, "R11", "op 7", 128'({s0[0], spi_cs}), 128'({1'b0, pins}));
        wr(3'd2, mk(2, 8, 3, 0));
        wr(3'd2, mk(3, 8, 0, 0));
        rd(3'd3, s0);
        chk(s0[0] == 1'b0 && spi_cs === pins, "R11", "op 3 and 0", 128'({s0[0], spi_cs}), 128'({1'b0, pins}));

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule